// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block sits right after the instruction memory read port of a simple 64-bit load/store processor. Each cycle the memory returns a ten-byte window that starts at the current program counter. The decoder splits that window into the fields the rest of the datapath consumes. From the head byte it takes an operation code and a function code. It classifies the operation: whether the code is legal, whether a register-specifier byte follows the head byte, and whether an eight-byte constant follows. It then pulls out the two register identifiers and the little-endian constant, and it forms the address of the next sequential instruction.

An instruction is 1, 2, 9 or 10 bytes long. The length depends only on the two presence flags. The decoder is purely combinational: its outputs follow the window and the PC inputs within the same cycle. It has no handshake of its own. The surrounding fetch stage owns the PC register, any valid/ready flow control and branch resolution. Since no data is held here, back-pressure is applied entirely by whoever holds the window steady. The outputs are meaningful for exactly as long as the inputs are stable.

Top module: `varlen_fetch_decoder`

## Requirements
- R1: `op_code` equals bits 7..4 of window byte 0 and `fn_code` equals bits 3..0 of window byte 0, where window byte k occupies `win_bytes[8k+7:8k]`.
- R2: `insn_bad` is 1 exactly when the operation code is 0xC or above. When `insn_bad` is 1, both `has_regbyte` and `has_const` are 0.
- R3: `has_regbyte` is 1 for operation codes 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB. It is 0 for 0x0, 0x1, 0x7, 0x8 and 0x9.
- R4: `has_const` is 1 for operation codes 0x3, 0x4, 0x5, 0x7 and 0x8, and 0 for every other code. While it is 0, `const_word` is zero.
- R5: With a register byte present, `reg_a` is bits 7..4 of byte 1 and `reg_b` is bits 3..0 of byte 1, so a 0xF in the byte passes through unchanged. Without a register byte, both outputs are 0xF.
- R6: With a constant present, `const_word` is assembled little-endian from the eight bytes that start at byte 2 when a register byte is present, and at byte 1 otherwise.
- R7: `seq_pc` equals `cur_pc` + 1 + (`has_regbyte` ? 1 : 0) + (`has_const` ? 8 : 0), modulo 2^64.
- R8: The resulting lengths are fixed per code: 0x0, 0x1 and 0x9 advance by 1; 0x2, 0x6, 0xA and 0xB advance by 2; 0x7 and 0x8 advance by 9; 0x3, 0x4 and 0x5 advance by 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| win_bytes | input | 80 | Instruction window read at the PC; byte k at bits 8k+7..8k |
| cur_pc | input | 64 | Address of window byte 0 |
| op_code | output | 4 | Operation code from the head byte |
| fn_code | output | 4 | Function code from the head byte |
| insn_bad | output | 1 | Operation code is not a defined one |
| has_regbyte | output | 1 | A register-specifier byte follows the head byte |
| has_const | output | 1 | An eight-byte constant is part of the instruction |
| reg_a | output | 4 | First register identifier, 0xF when absent |
| reg_b | output | 4 | Second register identifier, 0xF when absent |
| const_word | output | 64 | Little-endian constant, zero when absent |
| seq_pc | output | 64 | Address of the next sequential instruction |

## Verification
The hardest case to reach from the ports is a wrong constant offset that goes unnoticed. If the constant is taken from the wrong starting byte, the error is hidden whenever neighbouring window bytes happen to be equal. The stimulus therefore fills every window byte with a distinct pseudo-random value, and it sweeps all sixteen operation codes so that both constant offsets and both register-byte cases appear. A PC near the top of the address space exercises the wrap of the next-address sum.

// File: rtl/fdec_pkg.sv
`timescale 1ns/1ps
package fdec_pkg;
  parameter int unsigned NIB_W = 4;

  typedef enum logic [NIB_W-1:0] {
    OP_STOP   = 4'h0,
    OP_IDLE   = 4'h1,
    OP_RMOVE  = 4'h2,
    OP_IMOVE  = 4'h3,
    OP_STORE  = 4'h4,
    OP_LOAD   = 4'h5,
    OP_ALU    = 4'h6,
    OP_JUMP   = 4'h7,
    OP_CALL   = 4'h8,
    OP_RETURN = 4'h9,
    OP_PUSH   = 4'hA,
    OP_POP    = 4'hB
  } opc_e;

  localparam logic [NIB_W-1:0] NO_REG = '1;

  typedef struct packed {
    logic bad;
    logic reg_byte;
    logic const_word;
  } shape_t;
endpackage

// File: rtl/fdec_split.sv
`timescale 1ns/1ps
module fdec_split
  import fdec_pkg::*;
(
  input  logic [2*NIB_W-1:0] head,
  output logic [NIB_W-1:0]   op,
  output logic [NIB_W-1:0]   fn
);
  assign op = head[2*NIB_W-1:NIB_W];
  assign fn = head[NIB_W-1:0];
endmodule

// File: rtl/fdec_classify.sv
`timescale 1ns/1ps
module fdec_classify
  import fdec_pkg::*;
(
  input  logic [NIB_W-1:0] op,
  output shape_t           shape
);
  always_comb begin
    shape = '0;
    case (op)
      OP_STOP, OP_IDLE, OP_RETURN: ;
      OP_RMOVE, OP_ALU, OP_PUSH, OP_POP: shape.reg_byte = 1'b1;
      OP_IMOVE, OP_STORE, OP_LOAD: begin
        shape.reg_byte   = 1'b1;
        shape.const_word = 1'b1;
      end
      OP_JUMP, OP_CALL: shape.const_word = 1'b1;
      default: shape.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/fdec_align.sv
`timescale 1ns/1ps
module fdec_align
  import fdec_pkg::*;
#(
  parameter int unsigned WIN_BYTES   = 10,
  parameter int unsigned CONST_BYTES = 8
) (
  input  logic [WIN_BYTES*8-1:0]   win,
  input  logic                     has_reg,
  input  logic                     has_const,
  output logic [NIB_W-1:0]         reg_a,
  output logic [NIB_W-1:0]         reg_b,
  output logic [CONST_BYTES*8-1:0] const_word
);
  localparam int unsigned SPEC_LSB = 8;

  assign reg_a = has_reg ? win[SPEC_LSB+2*NIB_W-1 -: NIB_W] : NO_REG;
  assign reg_b = has_reg ? win[SPEC_LSB+NIB_W-1 -: NIB_W]   : NO_REG;

  // each constant byte picks from one of two window slots
  for (genvar k = 0; k < CONST_BYTES; k++) begin : g_cbyte
    logic [7:0] near_b, far_b;
    assign near_b = win[8*(k+1) +: 8];
    assign far_b  = win[8*(k+2) +: 8];
    assign const_word[8*k +: 8] = !has_const ? 8'h00 : (has_reg ? far_b : near_b);
  end
endmodule

// File: rtl/fdec_nextpc.sv
`timescale 1ns/1ps
module fdec_nextpc #(
  parameter int unsigned ADDR_W      = 64,
  parameter int unsigned CONST_BYTES = 8
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic              has_reg,
  input  logic              has_const,
  output logic [ADDR_W-1:0] seq_pc
);
  localparam int unsigned LEN_W = $clog2(CONST_BYTES + 3);
  logic [LEN_W-1:0] len;

  always_comb begin
    len = LEN_W'(1);
    if (has_reg)   len = len + LEN_W'(1);
    if (has_const) len = len + LEN_W'(CONST_BYTES);
  end

  assign seq_pc = pc + ADDR_W'(len);
endmodule

// File: rtl/varlen_fetch_decoder.sv
`timescale 1ns/1ps
module varlen_fetch_decoder
  import fdec_pkg::*;
#(
  parameter int unsigned WIN_BYTES   = 10,
  parameter int unsigned CONST_BYTES = 8,
  parameter int unsigned ADDR_W      = 64
) (
  input  logic [WIN_BYTES*8-1:0]   win_bytes,
  input  logic [ADDR_W-1:0]        cur_pc,
  output logic [NIB_W-1:0]         op_code,
  output logic [NIB_W-1:0]         fn_code,
  output logic                     insn_bad,
  output logic                     has_regbyte,
  output logic                     has_const,
  output logic [NIB_W-1:0]         reg_a,
  output logic [NIB_W-1:0]         reg_b,
  output logic [CONST_BYTES*8-1:0] const_word,
  output logic [ADDR_W-1:0]        seq_pc
);
  localparam logic [ADDR_W-1:0] STEP_ONE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_TWO  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP_JMP  = ADDR_W'(CONST_BYTES + 1);
  localparam logic [ADDR_W-1:0] STEP_FULL = ADDR_W'(CONST_BYTES + 2);

  shape_t shape;

  fdec_split u_split (
    .head (win_bytes[2*NIB_W-1:0]),
    .op   (op_code),
    .fn   (fn_code)
  );

  fdec_classify u_class (
    .op    (op_code),
    .shape (shape)
  );

  assign insn_bad    = shape.bad;
  assign has_regbyte = shape.reg_byte;
  assign has_const   = shape.const_word;

  fdec_align #(.WIN_BYTES(WIN_BYTES), .CONST_BYTES(CONST_BYTES)) u_align (
    .win        (win_bytes),
    .has_reg    (has_regbyte),
    .has_const  (has_const),
    .reg_a      (reg_a),
    .reg_b      (reg_b),
    .const_word (const_word)
  );

  fdec_nextpc #(.ADDR_W(ADDR_W), .CONST_BYTES(CONST_BYTES)) u_next (
    .pc        (cur_pc),
    .has_reg   (has_regbyte),
    .has_const (has_const),
    .seq_pc    (seq_pc)
  );

  // checks relating the classifier, aligner and address adder
  logic [ADDR_W-1:0] step;
  assign step = seq_pc - cur_pc;

  always_comb begin
    a_r2_bad_no_fields: assert (!insn_bad || (!has_regbyte && !has_const))
      else $error("R2: illegal code reports fields");
    a_r5_absent_regs: assert (has_regbyte || (reg_a == NO_REG && reg_b == NO_REG))
      else $error("R5: register ids not 0xF without register byte");
    a_r4_const_zero: assert (has_const || const_word == '0)
      else $error("R4: constant not zero while absent");
    a_r7_step_set: assert (step == STEP_ONE || step == STEP_TWO ||
                           step == STEP_JMP || step == STEP_FULL)
      else $error("R7: next address step outside length set");
    a_r8_store_full: assert (op_code != OP_STORE || step == STEP_FULL)
      else $error("R8: store not full length");
    a_r8_alu_short: assert (op_code != OP_ALU || step == STEP_TWO)
      else $error("R8: ALU op not two bytes");
    a_r3_stack_reg: assert (!(op_code == OP_PUSH || op_code == OP_POP) ||
                            (has_regbyte && !has_const))
      else $error("R3: stack op shape wrong");
  end
endmodule

// File: tb/varlen_fetch_decoder_tb_top.sv
`timescale 1ns/1ps
module varlen_fetch_decoder_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [79:0] win_bytes;
  logic [63:0] cur_pc;
  logic [3:0]  op_code, fn_code, reg_a, reg_b;
  logic        insn_bad, has_regbyte, has_const;
  logic [63:0] const_word, seq_pc;

  varlen_fetch_decoder dut_i (
    .win_bytes(win_bytes), .cur_pc(cur_pc), .op_code(op_code), .fn_code(fn_code),
    .insn_bad(insn_bad), .has_regbyte(has_regbyte), .has_const(has_const),
    .reg_a(reg_a), .reg_b(reg_b), .const_word(const_word), .seq_pc(seq_pc)
  );

  typedef struct {
    logic [63:0] pc;
    logic [3:0]  op, fn, ra, rb;
    logic        bad, hr, hc;
    logic [63:0] cw, nxt;
    logic [63:0] len;
  } exp_t;

  exp_t sb_q[$];
  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [63:0] nxt_rand(input logic [63:0] s);
    logic [63:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  // expected values from the requirement text
  function automatic exp_t model(input logic [63:0] pc, input logic [79:0] w);
    exp_t e;
    int base;
    e.pc  = pc;
    e.op  = w[7:4];
    e.fn  = w[3:0];
    e.bad = (e.op >= 4'hC);
    e.hr  = (e.op inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB});
    e.hc  = (e.op inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8});
    e.ra  = e.hr ? w[15:12] : 4'hF;
    e.rb  = e.hr ? w[11:8]  : 4'hF;
    base  = e.hr ? 2 : 1;
    e.cw  = '0;
    if (e.hc) for (int k = 0; k < 8; k++) e.cw[8*k +: 8] = w[8*(base+k) +: 8];
    e.nxt = pc + 64'd1 + (e.hr ? 64'd1 : 64'd0) + (e.hc ? 64'd8 : 64'd0);
    case (e.op)
      4'h0, 4'h1, 4'h9:             e.len = 64'd1;
      4'h2, 4'h6, 4'hA, 4'hB:       e.len = 64'd2;
      4'h7, 4'h8:                   e.len = 64'd9;
      4'h3, 4'h4, 4'h5:             e.len = 64'd10;
      default:                      e.len = 64'd0;
    endcase
    return e;
  endfunction

  task automatic send(input logic [63:0] pc, input logic [79:0] w);
    @(posedge clk);
    #1;
    cur_pc    = pc;
    win_bytes = w;
    sb_q.push_back(model(pc, w));
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(op_code == e.op, "R1 op_code", 64'(op_code), 64'(e.op));
      chk(fn_code == e.fn, "R1 fn_code", 64'(fn_code), 64'(e.fn));
      chk(insn_bad == e.bad, "R2 insn_bad", 64'(insn_bad), 64'(e.bad));
      if (!e.bad) begin
        chk(has_regbyte == e.hr, "R3 has_regbyte", 64'(has_regbyte), 64'(e.hr));
        chk(has_const == e.hc, "R4 has_const", 64'(has_const), 64'(e.hc));
        chk(reg_a == e.ra, "R5 reg_a", 64'(reg_a), 64'(e.ra));
        chk(reg_b == e.rb, "R5 reg_b", 64'(reg_b), 64'(e.rb));
        chk(const_word == e.cw, "R6 const_word", const_word, e.cw);
        chk(seq_pc == e.nxt, "R7 seq_pc", seq_pc, e.nxt);
        chk(seq_pc - e.pc == e.len, "R8 length", seq_pc - e.pc, e.len);
      end else begin
        chk(!has_regbyte && !has_const, "R2 flags when illegal",
            64'({has_regbyte, has_const}), 64'd0);
      end
    end
  end

  logic done = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [79:0] w;
    win_bytes = '0;
    cur_pc    = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-state: all-zero window decodes as a one-byte stop (R8)
    send(64'h0, 80'h0);
    // sweep every code, distinct bytes, several rounds (R1..R8)
    for (int round = 0; round < 6; round++) begin
      for (int op = 0; op < 16; op++) begin
        for (int b = 0; b < 10; b++) begin
          rng = nxt_rand(rng);
          w[8*b +: 8] = rng[7:0] ^ 8'(b * 37);
        end
        w[7:4] = 4'(op);
        rng = nxt_rand(rng);
        send(rng, w);
      end
    end
    // register byte 0xF in both halves passes through (R5)
    send(64'h1000, {64'h1122_3344_5566_7788, 8'hFF, 8'hA0});
    send(64'h1000, {64'h1122_3344_5566_7788, 8'hF3, 8'h30});
    // constant offsets with known bytes (R6)
    send(64'h2000, 80'h0011_2233_4455_6677_8870);
    send(64'h2000, 80'h0011_2233_4455_6677_8840);
    // next address wraps at the top of the address space (R7)
    send(64'hFFFF_FFFF_FFFF_FFFC, 80'h0011_2233_4455_6677_8830);
    send(64'hFFFF_FFFF_FFFF_FFFF, 80'h10);
    // illegal codes (R2)
    send(64'h3000, 80'hC5);
    send(64'h3000, 80'hFF);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule